// File: doc/BRIEF.md
# One-Bit Stream FIR Tap Driver

This block is the digital front end of a converter that turns a one-bit, 64x oversampled audio stream into drive signals for a resistor-weighted current FIR filter. A single system clock runs at four times the bit clock. On its falling edge the block samples the bit clock and the data bit. When it sees a rising transition of the bit clock, it shifts one new bit into two eight-stage delay lines. The HOT line receives the bit with the selected polarity. The COLD line receives the complement of that bit.

Each delay line stage drives one FIR tap on two buses: a positive bus carrying the stage value and a negative bus carrying its complement. A sub-bit phase counter returns every tap to zero during the last system-clock cycle of each bit period, so each tap is active for three of the four cycles. The polarity select and the active-low reset are sampled on the rising edge of the system clock. While reset is held, both delay lines hold an alternating pattern, so that the positive and negative buses carry equal numbers of active taps and the filter output sits at mid-scale.

The data stream has no valid/ready handshake and cannot be back-pressured. A new bit is defined only by a rising edge of the bit clock. A source pauses the stream by holding the bit clock steady, and during that time the taps keep their values.

Top module: `onebit_fir_tap_driver`

## Requirements
- R1: A bit period lasts four system-clock cycles. The sub-bit phase counter is set to 0 on the falling system-clock edge that performs a shift, then counts 1, 2 and 3 on the following falling edges.
- R2: `bit_in` and `bit_clk` are sampled on the falling edge of `sys_clk`. A shift happens on the falling edge after the first falling edge at which `bit_clk` is sampled high following a low sample. The new bit is visible on the tap buses right after that shift, in phase 0.
- R3: If no rising transition of `bit_clk` is detected, the delay lines do not shift, whatever `bit_in` does.
- R4: `polarity_inv` is sampled on the rising edge of `sys_clk`. When it is 0, the bit entering the HOT line equals `bit_in`. When it is 1, the bit entering the HOT line is the inverse of `bit_in`.
- R5: The bit entering the COLD line is always the complement of the bit entering the HOT line.
- R6: Tap bit 0 holds the newest bit and tap bit k holds the bit received k bit periods earlier (8 taps).
- R7: In phases 0 to 2, `hot_pos` equals the HOT line and `hot_neg` equals its complement; `cold_pos` and `cold_neg` do the same for the COLD line. In phase 3, all four buses are 0.
- R8: While `rst_n` is sampled low, both lines hold 8'hAA (odd taps set) and the phase is held at 0. The outputs are then `hot_pos` = `cold_pos` = 8'hAA and `hot_neg` = `cold_neg` = 8'h55, with four active taps on each bus, and they stay constant whatever `bit_clk` does.
- R9: After reset is released, the lines keep 8'hAA until the next detected rising transition of `bit_clk`, which shifts the first new bit in above that pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock, four cycles per data bit |
| rst_n | input | 1 | Active-low reset, sampled on the rising edge |
| polarity_inv | input | 1 | Polarity select (1 = invert), sampled on the rising edge |
| bit_clk | input | 1 | Data bit clock, sampled on the falling edge |
| bit_in | input | 1 | One-bit data stream, sampled on the falling edge |
| hot_pos | output | 8 | HOT positive tap bus, return-to-zero gated |
| hot_neg | output | 8 | HOT negative tap bus, return-to-zero gated |
| cold_pos | output | 8 | COLD positive tap bus, return-to-zero gated |
| cold_neg | output | 8 | COLD negative tap bus, return-to-zero gated |

## Verification
The return-to-zero quarter and the three active quarters are the hardest states to observe, because they last one system-clock cycle each and their position depends on where the bit-clock rise was detected. The stimulus drives the bit clock and data only on rising system-clock edges with a fixed two-high, two-low pattern. Every check is then timed by counting falling edges from that rise, so phase 0, phase 2 and phase 3 are each sampled at a known instant. The bench also produces a stall by holding the bit clock low while the data toggles for two full phase wraps, and it reapplies reset in the middle of a stream.

// File: rtl/ofd_pkg.sv
package ofd_pkg;

  // Mid-scale fill: odd-numbered taps set, even taps clear.
  function automatic logic [63:0] alt_fill();
    logic [63:0] v;
    for (int i = 0; i < 64; i++) begin
      v[i] = (i % 2) == 1;
    end
    return v;
  endfunction

endpackage

// File: rtl/ofd_ctrl_sync.sv
module ofd_ctrl_sync (
  input  logic clk,
  input  logic rst_n_in,
  input  logic inv_in,
  output logic run_q,
  output logic inv_q
);

  // Control pins are taken on the rising edge, opposite to the data.
  always_ff @(posedge clk) begin
    run_q <= rst_n_in;
    inv_q <= inv_in;
  end

endmodule

// File: rtl/ofd_bit_capture.sv
module ofd_bit_capture #(
  parameter int RATIO = 4,
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic          clk,
  input  logic          run,
  input  logic          bit_clk,
  input  logic          bit_in,
  output logic          shift_en,
  output logic          data_s,
  output logic [PW-1:0] phase
);

  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic bclk_s;
  logic bclk_p;

  // Data and bit clock are taken on the falling edge.
  always_ff @(negedge clk) begin
    bclk_s <= bit_clk;
    bclk_p <= bclk_s;
    data_s <= bit_in;
  end

  assign shift_en = bclk_s & ~bclk_p;

  // Sub-bit phase counter, realigned on every detected bit-clock rise.
  always_ff @(negedge clk) begin
    if (!run)                phase <= '0;
    else if (shift_en)       phase <= '0;
    else if (phase == LAST)  phase <= '0;
    else                     phase <= phase + PW'(1);
  end

  // R1: a shift always restarts the bit period at phase 0
  assert_phase_realign_R1: assert property (
    @(negedge clk) disable iff (!run)
    (shift_en && run) |=> (phase == '0)
  );

endmodule

// File: rtl/ofd_shift_line.sv
module ofd_shift_line #(
  parameter int TAPS = 8
) (
  input  logic            clk,
  input  logic            run,
  input  logic            shift_en,
  input  logic            bit_in,
  output logic [TAPS-1:0] line
);

  localparam logic [63:0]     FILL_FULL = ofd_pkg::alt_fill();
  localparam logic [TAPS-1:0] MID       = FILL_FULL[TAPS-1:0];

  always_ff @(negedge clk) begin
    if (!run)          line <= MID;
    else if (shift_en) line <= {line[TAPS-2:0], bit_in};
  end

  // R3: without a detected bit-clock rise the line holds still
  assert_hold_no_edge_R3: assert property (
    @(negedge clk) disable iff (!run)
    (!shift_en && run) |=> $stable(line)
  );

endmodule

// File: rtl/ofd_tap_gate.sv
module ofd_tap_gate #(
  parameter int TAPS  = 8,
  parameter int RATIO = 4,
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic [TAPS-1:0] line,
  input  logic [PW-1:0]   phase,
  output logic [TAPS-1:0] pos,
  output logic [TAPS-1:0] neg
);

  localparam logic [PW-1:0] RTZ = PW'(RATIO - 1);

  logic active;
  assign active = (phase != RTZ);

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign pos[k] = line[k]  & active;
    assign neg[k] = ~line[k] & active;
  end

endmodule

// File: rtl/onebit_fir_tap_driver.sv
module onebit_fir_tap_driver #(
  parameter int TAPS  = 8,
  parameter int RATIO = 4,
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic            sys_clk,
  input  logic            rst_n,
  input  logic            polarity_inv,
  input  logic            bit_clk,
  input  logic            bit_in,
  output logic [TAPS-1:0] hot_pos,
  output logic [TAPS-1:0] hot_neg,
  output logic [TAPS-1:0] cold_pos,
  output logic [TAPS-1:0] cold_neg
);

  localparam logic [63:0]     FILL_FULL = ofd_pkg::alt_fill();
  localparam logic [TAPS-1:0] MID       = FILL_FULL[TAPS-1:0];

  logic            run_q;
  logic            inv_q;
  logic            shift_en;
  logic            data_s;
  logic [PW-1:0]   phase;
  logic            hot_bit;
  logic            cold_bit;
  logic [TAPS-1:0] hot_line;
  logic [TAPS-1:0] cold_line;

  ofd_ctrl_sync u_ctrl (
    .clk      (sys_clk),
    .rst_n_in (rst_n),
    .inv_in   (polarity_inv),
    .run_q    (run_q),
    .inv_q    (inv_q)
  );

  ofd_bit_capture #(.RATIO(RATIO)) u_cap (
    .clk      (sys_clk),
    .run      (run_q),
    .bit_clk  (bit_clk),
    .bit_in   (bit_in),
    .shift_en (shift_en),
    .data_s   (data_s),
    .phase    (phase)
  );

  assign hot_bit  = data_s ^ inv_q;
  assign cold_bit = ~hot_bit;

  ofd_shift_line #(.TAPS(TAPS)) u_hot (
    .clk      (sys_clk),
    .run      (run_q),
    .shift_en (shift_en),
    .bit_in   (hot_bit),
    .line     (hot_line)
  );

  ofd_shift_line #(.TAPS(TAPS)) u_cold (
    .clk      (sys_clk),
    .run      (run_q),
    .shift_en (shift_en),
    .bit_in   (cold_bit),
    .line     (cold_line)
  );

  ofd_tap_gate #(.TAPS(TAPS), .RATIO(RATIO)) u_gate_hot (
    .line  (hot_line),
    .phase (phase),
    .pos   (hot_pos),
    .neg   (hot_neg)
  );

  ofd_tap_gate #(.TAPS(TAPS), .RATIO(RATIO)) u_gate_cold (
    .line  (cold_line),
    .phase (phase),
    .pos   (cold_pos),
    .neg   (cold_neg)
  );

  // R8: reset loads the mid-scale pattern into both lines
  assert_mid_fill_R8: assert property (
    @(negedge sys_clk)
    (run_q == 1'b0) |=> (hot_line == MID && cold_line == MID)
  );

  // R5: the newest HOT and COLD bits always form a complementary pair
  assert_pair_newest_R5: assert property (
    @(negedge sys_clk) disable iff (!run_q)
    (shift_en && run_q) |=> (hot_line[0] != cold_line[0])
  );

  // R7: phase 3 leaves no tap active on any bus
  assert_rtz_quiet_R7: assert property (
    @(negedge sys_clk) disable iff (!run_q)
    (phase == PW'(RATIO - 1)) |-> ((hot_pos | hot_neg | cold_pos | cold_neg) == '0)
  );

endmodule

// File: tb/onebit_fir_tap_driver_test.sv
module onebit_fir_tap_driver_test;

  localparam int CLK_PERIOD = 10;

  logic       sys_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       polarity_inv = 1'b0;
  logic       bit_clk = 1'b0;
  logic       bit_in = 1'b0;
  logic [7:0] hot_pos, hot_neg, cold_pos, cold_neg;

  int tests_run = 0;
  int tests_failed = 0;

  logic [7:0] exp_hot = 8'hAA;
  logic [7:0] exp_cold = 8'hAA;

  always #(CLK_PERIOD / 2) sys_clk = ~sys_clk;

  onebit_fir_tap_driver uut (
    .sys_clk      (sys_clk),
    .rst_n        (rst_n),
    .polarity_inv (polarity_inv),
    .bit_clk      (bit_clk),
    .bit_in       (bit_in),
    .hot_pos      (hot_pos),
    .hot_neg      (hot_neg),
    .cold_pos     (cold_pos),
    .cold_neg     (cold_neg)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests_run++;
    if (got !== exp) begin
      tests_failed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_active(input string tag);
    chk({tag, " R7 R6 hot_pos"},  hot_pos,  exp_hot);
    chk({tag, " R7 hot_neg"},     hot_neg,  ~exp_hot);
    chk({tag, " R7 R5 cold_pos"}, cold_pos, exp_cold);
    chk({tag, " R7 cold_neg"},    cold_neg, ~exp_cold);
  endtask

  // One bit period: bit clock high for two cycles, low for two.
  task automatic send_bit(input logic d, input string tag);
    logic nb;
    @(posedge sys_clk);
    bit_clk = 1'b1;
    bit_in  = d;
    @(posedge sys_clk);
    @(posedge sys_clk);
    bit_clk = 1'b0;
    nb = d ^ polarity_inv;
    exp_hot  = {exp_hot[6:0], nb};
    exp_cold = {exp_cold[6:0], ~nb};
    #1 chk_active({tag, " R2 phase0"});
    @(posedge sys_clk);
    #1 chk_active({tag, " R1 phase1"});
  endtask

  task automatic test_reset();
    repeat (4) @(posedge sys_clk);
    #1;
    chk("R8 reset hot_pos",  hot_pos,  8'hAA);
    chk("R8 reset hot_neg",  hot_neg,  8'h55);
    chk("R8 reset cold_pos", cold_pos, 8'hAA);
    chk("R8 reset cold_neg", cold_neg, 8'h55);
    chk("R8 balanced count", 8'($countones(hot_pos)), 8'($countones(hot_neg)));
    // bit clock toggling during reset has no effect
    for (int i = 0; i < 3; i++) begin
      @(posedge sys_clk); bit_clk = 1'b1; bit_in = 1'b1;
      @(posedge sys_clk);
      @(posedge sys_clk); bit_clk = 1'b0;
      @(posedge sys_clk);
    end
    #1;
    chk("R8 held hot_pos",  hot_pos,  8'hAA);
    chk("R8 held cold_neg", cold_neg, 8'h55);
  endtask

  task automatic test_release();
    @(negedge sys_clk);
    rst_n = 1'b1;
    @(posedge sys_clk);
    #1 chk("R9 release hot_pos", hot_pos, 8'hAA);
    @(negedge sys_clk);
    @(negedge sys_clk);
    #1 chk("R9 before edge cold_pos", cold_pos, 8'hAA);
    exp_hot  = 8'hAA;
    exp_cold = 8'hAA;
    send_bit(1'b1, "R9 first bit");
  endtask

  task automatic test_stream();
    logic [7:0] pat = 8'b0100_1101;
    for (int i = 0; i < 8; i++) begin
      send_bit(pat[i], "stream");
    end
    chk("R5 cold is complement after fill", exp_cold, ~exp_hot);
    @(negedge sys_clk);
    #1 chk_active("R1 phase2");
    @(negedge sys_clk);
    #1;
    chk("R7 rtz hot_pos",  hot_pos,  8'h00);
    chk("R7 rtz hot_neg",  hot_neg,  8'h00);
    chk("R7 rtz cold_pos", cold_pos, 8'h00);
    chk("R7 rtz cold_neg", cold_neg, 8'h00);
    send_bit(1'b0, "R1 after rtz");
  endtask

  task automatic test_stall();
    for (int i = 0; i < 8; i++) begin
      @(posedge sys_clk);
      bit_in = ~bit_in;
    end
    #1 chk_active("R3 stall");
    send_bit(1'b1, "R3 resume");
  endtask

  task automatic test_invert();
    @(negedge sys_clk);
    polarity_inv = 1'b1;
    send_bit(1'b1, "R4 inv one");
    chk("R4 inverted newest hot", {7'b0, hot_pos[0]}, 8'h00);
    send_bit(1'b0, "R4 inv zero");
    chk("R4 inverted newest cold", {7'b0, cold_pos[0]}, 8'h00);
    send_bit(1'b1, "R4 inv one b");
    @(negedge sys_clk);
    polarity_inv = 1'b0;
    send_bit(1'b1, "R4 normal");
    chk("R4 normal newest hot", {7'b0, hot_pos[0]}, 8'h01);
  endtask

  task automatic test_midreset();
    @(negedge sys_clk);
    rst_n = 1'b0;
    @(negedge sys_clk);
    @(negedge sys_clk);
    #1;
    chk("R8 midstream hot_pos",  hot_pos,  8'hAA);
    chk("R8 midstream cold_neg", cold_neg, 8'h55);
    exp_hot  = 8'hAA;
    exp_cold = 8'hAA;
    test_release();
    send_bit(1'b0, "R9 second bit");
    send_bit(1'b0, "R6 third bit");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    tests_failed++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    test_reset();
    test_release();
    test_stream();
    test_stall();
    test_invert();
    test_midreset();
    repeat (4) @(posedge sys_clk);
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule